// File: doc/BRIEF.md
# Dual-Lane Shift-Mask Interpolator

This block holds two accumulator lanes for table walks and fixed-point stepping. Each lane picks an input: its own accumulator, or the accumulator of the other lane. It shifts that input right by a set amount and keeps only a chosen, inclusive range of bits. The kept value can be sign-extended. The lane then adds its own base to form the lane result. A third base is added to the kept values of both lanes to form a combined full result.

Software drives the block through a simple register port. Each cycle allows one write and one read, and read data is registered. Reading a peek address returns a result and has no side effect. Reading a pop address returns the same kind of value and, on the same edge, loads both accumulators with their chosen results. A separate add address increments an accumulator atomically. Reading that add address returns the kept value with no base added.

Each lane also has three options. It can bypass the shift and mask for its own result. It can load the other lane's result on pop. It can force two upper bits into its result, but only in the copy returned on the bus.

Top module: `interp_dual`

## Requirements
- R1: After reset, every accumulator, base and control register reads as zero, and the first peek of the full result returns zero.
- R2: Word addresses are: 0/1 accumulators, 2/3/4 bases for lane 0, lane 1 and full, 5/6/7 pop lane0/lane1/full, 8/9/10 peek lane0/lane1/full, 11/12 lane controls, 13/14 add ports for lane 0 and lane 1. A write to an accumulator, base or control address reads back from the same address. Read data appears on the clock edge after the read request. In a cycle with no read request, read data is zero.
- R3: Control bits [4:0] give a logical right shift of the lane input. Bits [9:5] give the low bound of the kept range and bits [14:10] give the high bound, both inclusive. All other bits are cleared. A high bound below the low bound keeps nothing.
- R4: Control bit 15 sign-extends the kept value from its high-bound bit before the base is added. Lane reads then show the extended sum.
- R5: Control bit 16 makes a lane take the other lane's accumulator as input to its shift and mask. This selection also applies under the bypass of R6.
- R6: Control bit 18 makes the lane result equal to the lane base plus the selected input with no shift and no mask. The full result still uses the kept values.
- R7: Control bits [20:19] are ORed into bits [29:28] of a lane result only on the bus. The value written back on pop does not carry them.
- R8: A write to a lane's add address adds write data bits [23:0], zero-extended, to that lane's accumulator. Bits [31:24] are ignored.
- R9: A read from a lane's add address returns that lane's kept value, sign-extended if bit 15 is set, without the base.
- R10: The full result equals base 2 plus both lanes' kept values, modulo 2^32.
- R11: A peek read leaves both accumulators unchanged.
- R12: A read of any pop address loads each accumulator with its own lane result. If control bit 17 of that lane is set, it loads the other lane's result instead. The returned data uses the values from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (peek/pop/add reads) |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Registered read data |

## Verification
Directed settings isolate each option in turn. A shift with a mid-range window shows the order of shift and mask. An inverted window shows the empty mask. A negative value at the window top separates signed from unsigned handling. Cross-input set together with bypass shows that the input mux sits ahead of the bypass, and forced bits followed by a pop show that they stay out of the write-back. Long runs with random control words, accumulators and bases then mix all options, and after every pop the accumulators are read back to catch a wrong write-back source.

// File: rtl/interp_pkg.sv
package interp_pkg;

   localparam int SH_W   = 5;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      A_ACC0  = 4'd0,
      A_ACC1  = 4'd1,
      A_BASE0 = 4'd2,
      A_BASE1 = 4'd3,
      A_BASE2 = 4'd4,
      A_POP0  = 4'd5,
      A_POP1  = 4'd6,
      A_POPF  = 4'd7,
      A_PEEK0 = 4'd8,
      A_PEEK1 = 4'd9,
      A_PEEKF = 4'd10,
      A_CTRL0 = 4'd11,
      A_CTRL1 = 4'd12,
      A_ADD0  = 4'd13,
      A_ADD1  = 4'd14
   } reg_addr_e;

   typedef struct packed {
      logic [1:0]      force_hi;
      logic            raw_add;
      logic            cross_res;
      logic            cross_in;
      logic            sgn;
      logic [SH_W-1:0] msb;
      logic [SH_W-1:0] lsb;
      logic [SH_W-1:0] shift;
   } lane_ctrl_t;

   localparam int CTRL_W = $bits(lane_ctrl_t);

endpackage

// File: rtl/interp_mask_gen.sv
module interp_mask_gen #(
   parameter int DATA_W     = 32,
   parameter int SH_W       = 5,
   parameter int MASK_STYLE = 1
) (
   input  logic [SH_W-1:0]   lsb,
   input  logic [SH_W-1:0]   msb,
   output logic [DATA_W-1:0] mask
);

   if (DATA_W != (1 << SH_W)) begin : g_bad_width
      $error("interp_mask_gen: DATA_W must equal 2**SH_W");
   end

   if (MASK_STYLE == 0) begin : g_compare
      // one comparator pair per bit
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign mask[i] = (SH_W'(i) >= lsb) && (SH_W'(i) <= msb);
      end
   end else begin : g_arith
      // ones up to msb, intersected with ones from lsb
      logic [DATA_W:0]   upto;
      logic [DATA_W-1:0] from;
      always_comb begin
         upto = ((DATA_W+1)'(1) << ((SH_W+1)'(msb) + (SH_W+1)'(1))) - (DATA_W+1)'(1);
         from = {DATA_W{1'b1}} << lsb;
      end
      assign mask = upto[DATA_W-1:0] & from;
   end

   always_comb begin
      if (msb < lsb) begin
         p_empty_mask_r3: assert (mask == '0);
      end
   end

endmodule

// File: rtl/interp_lane_dp.sv
module interp_lane_dp #(
   parameter int DATA_W     = 32,
   parameter int SH_W       = 5,
   parameter int MASK_STYLE = 1
) (
   input  logic [DATA_W-1:0] lane_in,
   input  logic [DATA_W-1:0] base,
   input  logic [SH_W-1:0]   shift,
   input  logic [SH_W-1:0]   lsb,
   input  logic [SH_W-1:0]   msb,
   input  logic              sgn,
   input  logic              raw_add,
   output logic [DATA_W-1:0] smv,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] kept;
   logic [DATA_W:0]   low_ones;
   logic [DATA_W-1:0] ext_bits;
   logic [DATA_W-1:0] addend;

   interp_mask_gen #(
      .DATA_W    (DATA_W),
      .SH_W      (SH_W),
      .MASK_STYLE(MASK_STYLE)
   ) u_mask (
      .lsb (lsb),
      .msb (msb),
      .mask(mask)
   );

   always_comb begin
      shifted  = lane_in >> shift;
      kept     = shifted & mask;
      low_ones = ((DATA_W+1)'(1) << ((SH_W+1)'(msb) + (SH_W+1)'(1))) - (DATA_W+1)'(1);
      ext_bits = ~low_ones[DATA_W-1:0];
      smv      = (sgn && kept[msb]) ? (kept | ext_bits) : kept;
      addend   = raw_add ? lane_in : smv;
      result   = base + addend;
   end

   always_comb begin
      if (sgn && kept[msb]) begin
         p_sign_fill_r4: assert (smv[DATA_W-1] == 1'b1);
      end
   end

endmodule

// File: rtl/interp_regs.sv
module interp_regs #(
   parameter int DATA_W = 32,
   parameter int ADD_W  = 24
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [interp_pkg::ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          pop,
   input  logic [DATA_W-1:0]             wb   [2],
   output logic [DATA_W-1:0]             acc  [2],
   output logic [DATA_W-1:0]             base [3],
   output interp_pkg::lane_ctrl_t        ctrl [2]
);
   import interp_pkg::*;

   localparam int LANES = 2;

   if (ADD_W > DATA_W) begin : g_bad_add
      $error("interp_regs: ADD_W exceeds DATA_W");
   end

   logic [DATA_W-1:0] add_val;
   assign add_val = DATA_W'(wr_data[ADD_W-1:0]);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [ADDR_W-1:0] ACC_A  = ADDR_W'(32'(A_ACC0) + l);
      localparam logic [ADDR_W-1:0] ADD_A  = ADDR_W'(32'(A_ADD0) + l);
      localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(32'(A_CTRL0) + l);

      always_ff @(posedge clk) begin
         if (rst) begin
            acc[l] <= '0;
         end else if (wr_en && wr_addr == ACC_A) begin
            acc[l] <= wr_data;
         end else if (wr_en && wr_addr == ADD_A) begin
            acc[l] <= acc[l] + add_val;
         end else if (pop) begin
            acc[l] <= wb[l];
         end
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            ctrl[l] <= '0;
         end else if (wr_en && wr_addr == CTRL_A) begin
            ctrl[l] <= lane_ctrl_t'(wr_data[CTRL_W-1:0]);
         end
      end

      p_add_write_r8: assert property (@(posedge clk) disable iff (rst)
         (wr_en && wr_addr == ADD_A) |=> acc[l] == $past(acc[l]) + DATA_W'($past(wr_data[ADD_W-1:0])));
   end

   for (genvar b = 0; b < 3; b++) begin : g_base
      localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(32'(A_BASE0) + b);
      always_ff @(posedge clk) begin
         if (rst) begin
            base[b] <= '0;
         end else if (wr_en && wr_addr == BASE_A) begin
            base[b] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/interp_dual.sv
module interp_dual #(
   parameter int DATA_W     = 32,
   parameter int ADD_W      = 24,
   parameter int MASK_STYLE = 1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [interp_pkg::ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          rd_en,
   input  logic [interp_pkg::ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]             rd_data
);
   import interp_pkg::*;

   localparam int LANES     = 2;
   localparam int FORCE_LSB = DATA_W - 4;

   if (DATA_W != (1 << SH_W)) begin : g_bad_width
      $error("interp_dual: DATA_W must equal 2**SH_W");
   end

   logic [DATA_W-1:0] acc     [LANES];
   logic [DATA_W-1:0] base    [3];
   lane_ctrl_t        ctrl    [LANES];
   logic [DATA_W-1:0] lane_in [LANES];
   logic [DATA_W-1:0] smv     [LANES];
   logic [DATA_W-1:0] res     [LANES];
   logic [DATA_W-1:0] bus_res [LANES];
   logic [DATA_W-1:0] wb      [LANES];
   logic [DATA_W-1:0] full;
   logic              pop;
   logic              peek;

   assign pop  = rd_en && (rd_addr == A_POP0 || rd_addr == A_POP1 || rd_addr == A_POPF);
   assign peek = rd_en && (rd_addr == A_PEEK0 || rd_addr == A_PEEK1 || rd_addr == A_PEEKF);

   interp_regs #(
      .DATA_W(DATA_W),
      .ADD_W (ADD_W)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .pop    (pop),
      .wb     (wb),
      .acc    (acc),
      .base   (base),
      .ctrl   (ctrl)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_in[l] = ctrl[l].cross_in ? acc[LANES-1-l] : acc[l];

      interp_lane_dp #(
         .DATA_W    (DATA_W),
         .SH_W      (SH_W),
         .MASK_STYLE(MASK_STYLE)
      ) u_dp (
         .lane_in(lane_in[l]),
         .base   (base[l]),
         .shift  (ctrl[l].shift),
         .lsb    (ctrl[l].lsb),
         .msb    (ctrl[l].msb),
         .sgn    (ctrl[l].sgn),
         .raw_add(ctrl[l].raw_add),
         .smv    (smv[l]),
         .result (res[l])
      );

      assign bus_res[l] = res[l] | (DATA_W'(ctrl[l].force_hi) << FORCE_LSB);
      assign wb[l]      = ctrl[l].cross_res ? res[LANES-1-l] : res[l];
   end

   assign full = base[2] + smv[0] + smv[1];

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
      end else if (rd_en) begin
         case (rd_addr)
            A_ACC0:           rd_data <= acc[0];
            A_ACC1:           rd_data <= acc[1];
            A_BASE0:          rd_data <= base[0];
            A_BASE1:          rd_data <= base[1];
            A_BASE2:          rd_data <= base[2];
            A_POP0,  A_PEEK0: rd_data <= bus_res[0];
            A_POP1,  A_PEEK1: rd_data <= bus_res[1];
            A_POPF,  A_PEEKF: rd_data <= full;
            A_CTRL0:          rd_data <= DATA_W'(ctrl[0]);
            A_CTRL1:          rd_data <= DATA_W'(ctrl[1]);
            A_ADD0:           rd_data <= smv[0];
            A_ADD1:           rd_data <= smv[1];
            default:          rd_data <= '0;
         endcase
      end else begin
         rd_data <= '0;
      end
   end

   p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> rd_data == '0);

   p_peek_keeps_acc_r11: assert property (@(posedge clk) disable iff (rst)
      (peek && !wr_en) |=> ($stable(acc[0]) && $stable(acc[1])));

   p_pop_loads_lane0_r12: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_addr == A_POP0 && !wr_en && !ctrl[0].cross_res && ctrl[0].force_hi == 2'b00)
      |=> acc[0] == rd_data);

endmodule

// File: tb/interp_dual_tb.sv
module interp_dual_tb;

   localparam int CLK_PERIOD = 10;

   localparam logic [3:0] ACC0 = 4'd0,  ACC1 = 4'd1,  BASE0 = 4'd2, BASE1 = 4'd3,
                          BASE2 = 4'd4, POP0 = 4'd5,  POP1 = 4'd6,  POPF = 4'd7,
                          PEEK0 = 4'd8, PEEK1 = 4'd9, PEEKF = 4'd10,
                          CTRL0 = 4'd11, CTRL1 = 4'd12, ADD0 = 4'd13, ADD1 = 4'd14;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic rd_pend = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   logic [31:0] m_acc  [2];
   logic [31:0] m_base [3];
   logic [20:0] m_ctrl [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   interp_dual u_dut (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_en  (rd_en),
      .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   // ---------------- reference model ----------------
   function automatic logic [20:0] mk_ctrl(int sh, int lo, int hi, bit sg, bit xin,
                                           bit xres, bit raw, int frc);
      return {2'(frc), raw, xres, xin, sg, 5'(hi), 5'(lo), 5'(sh)};
   endfunction

   function automatic logic [31:0] m_in(int l);
      return m_ctrl[l][16] ? m_acc[1-l] : m_acc[l];
   endfunction

   function automatic logic [31:0] m_smv(int l);
      logic [31:0] v;
      logic [31:0] r;
      int sh, lo, hi;
      sh = int'(m_ctrl[l][4:0]);
      lo = int'(m_ctrl[l][9:5]);
      hi = int'(m_ctrl[l][14:10]);
      v  = m_in(l) >> sh;
      r  = '0;
      for (int i = 0; i < 32; i++) if (i >= lo && i <= hi) r[i] = v[i];
      if (m_ctrl[l][15] && hi >= lo && r[hi])
         for (int j = hi + 1; j < 32; j++) r[j] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] m_res(int l);
      return m_base[l] + (m_ctrl[l][18] ? m_in(l) : m_smv(l));
   endfunction

   function automatic logic [31:0] m_full();
      return m_base[2] + m_smv(0) + m_smv(1);
   endfunction

   function automatic logic [31:0] m_read(logic [3:0] a);
      case (a)
         ACC0: return m_acc[0];
         ACC1: return m_acc[1];
         BASE0: return m_base[0];
         BASE1: return m_base[1];
         BASE2: return m_base[2];
         POP0, PEEK0: return m_res(0) | {2'b00, m_ctrl[0][20:19], 28'h0};
         POP1, PEEK1: return m_res(1) | {2'b00, m_ctrl[1][20:19], 28'h0};
         POPF, PEEKF: return m_full();
         CTRL0: return 32'(m_ctrl[0]);
         CTRL1: return 32'(m_ctrl[1]);
         ADD0: return m_smv(0);
         ADD1: return m_smv(1);
         default: return '0;
      endcase
   endfunction

   // ---------------- driver ----------------
   task automatic bus_wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
      case (a)
         ACC0: m_acc[0] = d;
         ACC1: m_acc[1] = d;
         BASE0: m_base[0] = d;
         BASE1: m_base[1] = d;
         BASE2: m_base[2] = d;
         CTRL0: m_ctrl[0] = d[20:0];
         CTRL1: m_ctrl[1] = d[20:0];
         ADD0: m_acc[0] = m_acc[0] + {8'h0, d[23:0]};
         ADD1: m_acc[1] = m_acc[1] + {8'h0, d[23:0]};
         default: ;
      endcase
   endtask

   task automatic bus_rd(logic [3:0] a, string tag);
      logic [31:0] n0, n1;
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      exp_q.push_back(m_read(a));
      tag_q.push_back(tag);
      if (a == POP0 || a == POP1 || a == POPF) begin
         n0 = m_ctrl[0][17] ? m_res(1) : m_res(0);
         n1 = m_ctrl[1][17] ? m_res(0) : m_res(1);
         m_acc[0] = n0;
         m_acc[1] = n1;
      end
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   // ---------------- monitor ----------------
   always @(posedge clk) rd_pend <= rd_en;

   always @(negedge clk) begin
      if (rd_pend && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_checks++;
         if (rd_data !== e) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", t, rd_data, e);
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_ctrl[i] = '0; end
      for (int i = 0; i < 3; i++) m_base[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R1 reset state
      bus_rd(ACC0,  "R1 acc0 after reset");
      bus_rd(CTRL1, "R1 ctrl1 after reset");
      bus_rd(BASE2, "R1 base2 after reset");
      bus_rd(PEEKF, "R1 full after reset");

      // R2 idle data and readback
      @(negedge clk); @(negedge clk);
      n_checks++;
      if (rd_data !== 32'h0) begin
         n_fail++;
         $display("FAIL R2 idle rd_data: actual %08h expected 00000000", rd_data);
      end
      bus_wr(BASE0, 32'h1234_5678);
      bus_rd(BASE0, "R2 base0 readback");
      bus_wr(CTRL0, 32'(mk_ctrl(3, 1, 6, 0, 0, 1, 0, 2)));
      bus_rd(CTRL0, "R2 ctrl0 readback");

      // R3 shift then mask, and empty window
      bus_wr(CTRL0, 32'(mk_ctrl(4, 2, 9, 0, 0, 0, 0, 0)));
      bus_wr(ACC0, 32'hABCD_1234);
      bus_rd(ADD0,  "R3 shift/mask window");
      bus_rd(PEEK0, "R3 lane0 with base");
      bus_wr(CTRL0, 32'(mk_ctrl(0, 10, 3, 1, 0, 0, 0, 0)));
      bus_rd(ADD0,  "R3 msb below lsb gives zero");

      // R4 sign extension
      bus_wr(BASE0, 32'h0000_0100);
      bus_wr(CTRL0, 32'(mk_ctrl(0, 0, 7, 1, 0, 0, 0, 0)));
      bus_wr(ACC0, 32'h0000_0080);
      bus_rd(ADD0,  "R4 sign-extended kept value");
      bus_rd(PEEK0, "R4 signed sum with base");

      // R5 + R6 cross input under bypass
      bus_wr(ACC1, 32'h0F0F_0003);
      bus_wr(CTRL0, 32'(mk_ctrl(8, 0, 3, 0, 1, 0, 1, 0)));
      bus_rd(PEEK0, "R5 R6 cross input with raw add");
      bus_rd(PEEKF, "R6 full still masked");
      bus_wr(CTRL0, 32'(mk_ctrl(8, 0, 7, 0, 1, 0, 0, 0)));
      bus_rd(ADD0,  "R5 cross input to shift/mask");

      // R7 forced bits on bus only
      bus_wr(CTRL0, 32'(mk_ctrl(0, 0, 31, 0, 0, 0, 0, 3)));
      bus_wr(ACC0, 32'h0000_0011);
      bus_rd(PEEK0, "R7 forced bits on peek");
      bus_rd(POP0,  "R7 forced bits on pop");
      bus_rd(ACC0,  "R7 write-back without forced bits");

      // R8 atomic add of low 24 bits
      bus_wr(ADD0, 32'hFF00_0010);
      bus_rd(ACC0, "R8 add ignores upper byte");
      bus_wr(ADD1, 32'h00FF_FFFF);
      bus_rd(ACC1, "R8 add full 24 bits");

      // R9 add read excludes base, R10 full
      bus_wr(BASE1, 32'h7000_0000);
      bus_wr(BASE2, 32'hFFFF_FFF0);
      bus_wr(CTRL1, 32'(mk_ctrl(1, 0, 15, 0, 0, 0, 0, 0)));
      bus_rd(ADD1,  "R9 add read without base");
      bus_rd(PEEKF, "R10 full result wraps");

      // R11 peek has no side effect
      bus_rd(PEEK0, "R11 peek lane0");
      bus_rd(PEEK1, "R11 peek lane1");
      bus_rd(ACC0,  "R11 acc0 unchanged");
      bus_rd(ACC1,  "R11 acc1 unchanged");

      // R12 pop with cross result
      bus_wr(CTRL0, 32'(mk_ctrl(0, 0, 31, 0, 0, 1, 0, 0)));
      bus_rd(POPF, "R12 pop full");
      bus_rd(ACC0, "R12 acc0 took lane1 result");
      bus_rd(ACC1, "R12 acc1 took own result");

      // random mix of all options
      for (int it = 0; it < 250; it++) begin
         bus_wr(CTRL0, $urandom & 32'h001F_FFFF);
         bus_wr(CTRL1, $urandom & 32'h001F_FFFF);
         if (it % 3 == 0) begin
            bus_wr(ACC0, $urandom);
            bus_wr(ACC1, $urandom);
            bus_wr(BASE0, $urandom);
            bus_wr(BASE1, $urandom);
            bus_wr(BASE2, $urandom);
         end
         bus_wr(($urandom % 2) ? ADD0 : ADD1, $urandom);
         bus_rd(PEEK0, "R3 R4 R5 R6 R7 random peek lane0");
         bus_rd(PEEK1, "R3 R4 R5 R6 R7 random peek lane1");
         bus_rd(PEEKF, "R10 random full");
         bus_rd(ADD0,  "R9 random add read lane0");
         bus_rd(ADD1,  "R9 random add read lane1");
         case ($urandom % 3)
            0: bus_rd(POP0, "R12 random pop lane0");
            1: bus_rd(POP1, "R12 random pop lane1");
            default: bus_rd(POPF, "R12 random pop full");
         endcase
         bus_rd(ACC0, "R12 random acc0 after pop");
         bus_rd(ACC1, "R12 random acc1 after pop");
      end

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule